// File: doc/BRIEF.md
# Power-Management Event Router

This block gathers power-management and legacy event pulses from many sources and records each one in a sticky status flag. Sources in the gated group count only when their own enable flag is also set. Sources in the ungated group count as soon as their flag is set. The qualified events are combined into one pending condition. That condition goes either to an active-low system-management interrupt (SMI) or to an active-high system control interrupt (SCI), chosen by a single mode flag.

The SMI output is one-shot. Once it fires, it holds asserted and will not fire again until software writes the end-of-SMI strobe. The SCI output is a level that follows the pending condition. It is driven onto one of seven interrupt lines. Four of those lines can be used only when APIC mode is set.

Software reaches all status, enable and control fields through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational and return the value for the presented address. Status flags are cleared by writing 1 to their bit positions. Every event input and every output is a plain level or pulse, with no handshake.

Top module: `pmev_router`

## Requirements
- R1: Every status flag sets on a one-cycle event pulse and clears only when software writes 1 to its bit with a write to that status register. If an event and a clear reach the same bit in the same cycle, the flag stays set.
- R2: A gated source (status at address 1, enable at address 2, bit i for `gated_evt[i]`) contributes to the pending condition only while both its status and its enable are 1.
- R3: An ungated source (status at address 3, bit i for `ungated_evt[i]`) has no enable register and contributes whenever its status is 1.
- R4: Control register (address 0) bit 0 selects the mode. When bit 0 is 1, a pending condition drives SCI and `smi_n` stays 1. When bit 0 is 0, pending drives SMI and every `sci_line` bit stays 0.
- R5: With the global SMI enable (control bit 1) at 0, `smi_n` stays 1 while status flags keep latching. Setting the bit with an event still pending asserts SMI one cycle after the write.
- R6: SMI goes low the cycle after the pending condition is first seen while the output is armed. It then stays low, and clearing the status does not release it.
- R7: Writing 1 to control bit 2 (end-of-SMI, reads as 0) releases `smi_n` in the cycle after the write and re-arms the output. If anything is still pending, `smi_n` falls again one cycle later.
- R8: Control bits 8:4 hold the SCI line number. Values 9, 10 and 11 drive `sci_line` bits 0, 1 and 2. Values 20 to 23 drive bits 3 to 6. Any other value drives no line.
- R9: Line numbers 20 to 23 drive their bits only when APIC mode (control bit 3) is 1. Otherwise they drive no line.
- R10: Only `gpi_evt[15:0]` are latched, at address 4 with enables at address 5. Pulses on `gpi_evt[31:16]` set nothing and raise no interrupt.
- R11: A `pme_msg` pulse sets bit 0 of the extra status register (address 6). It raises an interrupt only while bit 0 of the extra enable register (address 7) is 1.
- R12: A `pwrbtn_ovr_evt` pulse sets bit 1 of address 6. This flag has no enable, so setting the SCI mode bit while it is still set raises SCI.
- R13: After reset all status, enable and control fields read 0, `smi_n` is 1, `sci_line` is 0, and the SMI output is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| gated_evt | input | 12 | Event pulses of sources that have an enable |
| ungated_evt | input | 3 | Event pulses of sources that have no enable |
| gpi_evt | input | 32 | General-purpose input event pulses (only 15:0 are used) |
| pme_msg | input | 1 | PCIe power-management message received pulse |
| pwrbtn_ovr_evt | input | 1 | Power-button override event pulse |
| smi_n | output | 1 | Active-low system-management interrupt |
| sci_line | output | 7 | One-hot SCI on lines 9, 10, 11, 20, 21, 22, 23 |

## Verification
A status flag stuck at 1 or lost shows at the ports one cycle after the event: it appears in a status read-back, and if the flag is enabled it also shows on an interrupt output. A wrong arming state shows as SMI firing twice without an end-of-SMI write, or as SMI failing to fall one cycle after the re-arm while something is still pending. Both can be seen within two cycles of the write. Wrong line decoding or a missing APIC-mode check appears on `sci_line` in the same cycle the control register changes, so the bench tries every legal line value and one illegal value, each with APIC mode both off and on.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
  localparam int DW        = 32;
  localparam int ADDR_W    = 4;
  localparam int LSEL_W    = 5;
  localparam int NUM_LINES = 7;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_GSTS   = 4'd1;
  localparam logic [ADDR_W-1:0] A_GEN    = 4'd2;
  localparam logic [ADDR_W-1:0] A_USTS   = 4'd3;
  localparam logic [ADDR_W-1:0] A_GPISTS = 4'd4;
  localparam logic [ADDR_W-1:0] A_GPIEN  = 4'd5;
  localparam logic [ADDR_W-1:0] A_XSTS   = 4'd6;
  localparam logic [ADDR_W-1:0] A_XEN    = 4'd7;

  localparam int C_SCI  = 0;
  localparam int C_GBL  = 1;
  localparam int C_EOS  = 2;
  localparam int C_APIC = 3;
  localparam int C_SEL  = 4;

  // interrupt line number carried by sci_line bit i
  function automatic int unsigned line_num(input int unsigned i);
    return (i < 3) ? 9 + i : 17 + i;
  endfunction

  function automatic bit apic_only(input int unsigned i);
    return i >= 3;
  endfunction
endpackage

// File: rtl/pmev_sts_bank.sv
module pmev_sts_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] EN_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_evt,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sts,
  output logic [W-1:0] en_rd,
  output logic         hit
);
  logic [W-1:0] en_eff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                     sts[i] <= 1'b0;
      else if (set_evt[i])            sts[i] <= 1'b1;
      else if (clr_wr && wdata[i])    sts[i] <= 1'b0;
    end

    if (EN_MASK[i]) begin : g_en
      logic en_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= wdata[i];
      end
      assign en_eff[i] = en_q;
      assign en_rd[i]  = en_q;
    end else begin : g_noen
      assign en_eff[i] = 1'b1;
      assign en_rd[i]  = 1'b0;
    end

    assert_set_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> sts[i]) else $error("status bit did not set");
    assert_w1c_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wdata[i] && !set_evt[i]) |=> !sts[i]) else $error("status bit did not clear");
    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !(clr_wr && wdata[i])) |=> sts[i]) else $error("status bit dropped");
  end

  assign hit = |(sts & en_eff);
endmodule

// File: rtl/pmev_smi_ctl.sv
module pmev_smi_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic sci_mode,
  input  logic gbl_en,
  input  logic eos_wr,
  output logic smi_n
);
  logic armed_q, smi_q, fire;

  assign fire = armed_q && pending && gbl_en && !sci_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      smi_q   <= 1'b0;
    end else if (eos_wr) begin
      armed_q <= 1'b1;
      smi_q   <= 1'b0;
    end else if (fire) begin
      armed_q <= 1'b0;
      smi_q   <= 1'b1;
    end
  end

  assign smi_n = !(smi_q && gbl_en && !sci_mode);

  assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eos_wr) |=> !armed_q) else $error("SMI re-armed without end-of-SMI");
  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eos_wr |=> (smi_n && armed_q)) else $error("end-of-SMI did not release and re-arm");
endmodule

// File: rtl/pmev_sci_steer.sv
module pmev_sci_steer
  import pmev_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 apic,
  input  logic [LSEL_W-1:0]    sel,
  output logic [NUM_LINES-1:0] line
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [LSEL_W-1:0] NUM = LSEL_W'(line_num(i));
    if (apic_only(i)) begin : g_apic
      assign line[i] = active && apic && (sel == NUM);
    end else begin : g_legacy
      assign line[i] = active && (sel == NUM);
    end
  end

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line)) else $error("more than one SCI line driven");
  assert_apic_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !apic |-> (line[NUM_LINES-1:3] == '0)) else $error("APIC-only line outside APIC mode");
endmodule

// File: rtl/pmev_router.sv
module pmev_router
  import pmev_pkg::*;
#(
  parameter int NUM_GATED   = 12,
  parameter int NUM_UNGATED = 3,
  parameter int GPI_W       = 32,
  parameter int GPI_ROUTED  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  input  logic [NUM_GATED-1:0]   gated_evt,
  input  logic [NUM_UNGATED-1:0] ungated_evt,
  input  logic [GPI_W-1:0]       gpi_evt,
  input  logic                   pme_msg,
  input  logic                   pwrbtn_ovr_evt,
  output logic                   smi_n,
  output logic [NUM_LINES-1:0]   sci_line
);
  localparam int XW = 2;

  logic              sci_mode_q, gbl_q, apic_q;
  logic [LSEL_W-1:0] sel_q;
  logic              ctrl_wr, eos_wr, pending;

  logic [NUM_GATED-1:0]   g_sts, g_en;
  logic [NUM_UNGATED-1:0] u_sts, u_en_unused;
  logic [GPI_ROUTED-1:0]  p_sts, p_en;
  logic [XW-1:0]          x_sts, x_en;
  logic                   g_hit, u_hit, p_hit, x_hit;

  logic gpi_hi_unused, wdata_unused;
  assign gpi_hi_unused = |gpi_evt[GPI_W-1:GPI_ROUTED];
  assign wdata_unused  = ^reg_wdata;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign eos_wr  = ctrl_wr && reg_wdata[C_EOS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_mode_q <= 1'b0;
      gbl_q      <= 1'b0;
      apic_q     <= 1'b0;
      sel_q      <= '0;
    end else if (ctrl_wr) begin
      sci_mode_q <= reg_wdata[C_SCI];
      gbl_q      <= reg_wdata[C_GBL];
      apic_q     <= reg_wdata[C_APIC];
      sel_q      <= reg_wdata[C_SEL +: LSEL_W];
    end
  end

  pmev_sts_bank #(.W(NUM_GATED), .EN_MASK('1)) u_gated (
    .clk, .rst_n, .set_evt(gated_evt),
    .clr_wr(reg_wr && reg_addr == A_GSTS), .en_wr(reg_wr && reg_addr == A_GEN),
    .wdata(reg_wdata[NUM_GATED-1:0]), .sts(g_sts), .en_rd(g_en), .hit(g_hit));

  pmev_sts_bank #(.W(NUM_UNGATED), .EN_MASK('0)) u_ungated (
    .clk, .rst_n, .set_evt(ungated_evt),
    .clr_wr(reg_wr && reg_addr == A_USTS), .en_wr(1'b0),
    .wdata(reg_wdata[NUM_UNGATED-1:0]), .sts(u_sts), .en_rd(u_en_unused), .hit(u_hit));

  pmev_sts_bank #(.W(GPI_ROUTED), .EN_MASK('1)) u_gpi (
    .clk, .rst_n, .set_evt(gpi_evt[GPI_ROUTED-1:0]),
    .clr_wr(reg_wr && reg_addr == A_GPISTS), .en_wr(reg_wr && reg_addr == A_GPIEN),
    .wdata(reg_wdata[GPI_ROUTED-1:0]), .sts(p_sts), .en_rd(p_en), .hit(p_hit));

  // bit 0: PCIe PME (enabled), bit 1: power-button override (no enable)
  pmev_sts_bank #(.W(XW), .EN_MASK(2'b01)) u_extra (
    .clk, .rst_n, .set_evt({pwrbtn_ovr_evt, pme_msg}),
    .clr_wr(reg_wr && reg_addr == A_XSTS), .en_wr(reg_wr && reg_addr == A_XEN),
    .wdata(reg_wdata[XW-1:0]), .sts(x_sts), .en_rd(x_en), .hit(x_hit));

  assign pending = g_hit || u_hit || p_hit || x_hit;

  pmev_smi_ctl u_smi (
    .clk, .rst_n, .pending, .sci_mode(sci_mode_q), .gbl_en(gbl_q),
    .eos_wr, .smi_n);

  pmev_sci_steer u_steer (
    .clk, .rst_n, .active(sci_mode_q && pending), .apic(apic_q),
    .sel(sel_q), .line(sci_line));

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[C_SCI]            = sci_mode_q;
        reg_rdata[C_GBL]            = gbl_q;
        reg_rdata[C_APIC]           = apic_q;
        reg_rdata[C_SEL +: LSEL_W]  = sel_q;
      end
      A_GSTS:   reg_rdata = DW'(g_sts);
      A_GEN:    reg_rdata = DW'(g_en);
      A_USTS:   reg_rdata = DW'(u_sts);
      A_GPISTS: reg_rdata = DW'(p_sts);
      A_GPIEN:  reg_rdata = DW'(p_en);
      A_XSTS:   reg_rdata = DW'(x_sts);
      A_XEN:    reg_rdata = DW'(x_en);
      default:  reg_rdata = '0;
    endcase
  end

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!smi_n && (|sci_line))) else $error("SMI and SCI active together");
  assert_gbl_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gbl_q && !ctrl_wr) |=> smi_n) else $error("SMI without global enable");
endmodule

// File: tb/sim_pmev_router.sv
module sim_pmev_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] gated_evt = '0;
  logic [2:0]  ungated_evt = '0;
  logic [31:0] gpi_evt = '0;
  logic        pme_msg = 1'b0;
  logic        pwrbtn_ovr_evt = 1'b0;
  logic        smi_n;
  logic [6:0]  sci_line;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pmev_router u0 (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit sci, input bit gbl, input bit eos,
                                      input bit apic, input int sel);
    return {23'd0, sel[4:0], apic, eos, gbl, sci};
  endfunction

  task automatic cleanup();
    for (int a = 1; a <= 7; a++) wr(4'(a), (a == 2 || a == 5 || a == 7) ? 32'h0 : 32'hFFFF_FFFF);
    wr(4'd0, ctl(0, 0, 1, 0, 0));
    tick();
  endtask

  task automatic pulse_g(input int i);
    gated_evt[i] = 1'b1; tick(); gated_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R13 smi_n", 32'(smi_n), 1);
    chk("R13 sci_line", 32'(sci_line), 0);
    for (int a = 0; a <= 7; a++) begin
      rd(4'(a), d);
      chk("R13 register", d, 0);
    end
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    cleanup();
    pulse_g(3);
    rd(4'd1, d); chk("R1 set", d, 32'h8);
    tick(); rd(4'd1, d); chk("R1 sticky", d, 32'h8);
    gated_evt[3] = 1'b1; wr(4'd1, 32'h8); gated_evt = '0;
    rd(4'd1, d); chk("R1 set beats clear", d, 32'h8);
    wr(4'd1, 32'h8);
    rd(4'd1, d); chk("R1 clear", d, 32'h0);
  endtask

  task automatic t_gated();
    cleanup();
    wr(4'd0, ctl(0, 1, 0, 0, 0));
    pulse_g(5); tick(); tick();
    chk("R2 no enable no SMI", 32'(smi_n), 1);
    wr(4'd2, 32'h20); tick();
    chk("R2 enable releases SMI", 32'(smi_n), 0);
  endtask

  task automatic t_ungated();
    cleanup();
    wr(4'd0, ctl(0, 1, 0, 0, 0));
    ungated_evt[1] = 1'b1; tick(); ungated_evt = '0;
    tick();
    chk("R3 ungated SMI", 32'(smi_n), 0);
  endtask

  task automatic t_oneshot();
    cleanup();
    wr(4'd2, 32'h1);
    wr(4'd0, ctl(0, 1, 0, 0, 0));
    pulse_g(0); tick();
    chk("R6 SMI asserts", 32'(smi_n), 0);
    wr(4'd1, 32'h1); tick();
    chk("R6 SMI held after clear", 32'(smi_n), 0);
    pulse_g(0); tick(); tick();
    chk("R6 still held", 32'(smi_n), 0);
    wr(4'd0, ctl(0, 1, 1, 0, 0));
    chk("R7 released after EOS", 32'(smi_n), 1);
    tick();
    chk("R7 reasserts while pending", 32'(smi_n), 0);
    wr(4'd1, 32'h1);
    wr(4'd0, ctl(0, 1, 1, 0, 0));
    tick(); tick();
    chk("R7 stays released", 32'(smi_n), 1);
  endtask

  task automatic t_gbl();
    logic [31:0] d;
    cleanup();
    wr(4'd2, 32'h2);
    pulse_g(1); tick(); tick();
    chk("R5 no SMI without global", 32'(smi_n), 1);
    rd(4'd1, d); chk("R5 status latched", d, 32'h2);
    wr(4'd0, ctl(0, 1, 0, 0, 0)); tick();
    chk("R5 SMI after global set", 32'(smi_n), 0);
  endtask

  task automatic t_sci();
    cleanup();
    wr(4'd2, 32'h80);
    wr(4'd0, ctl(1, 1, 0, 0, 9));
    pulse_g(7); tick();
    chk("R4 SCI line 9", 32'(sci_line), 32'h1);
    chk("R4 no SMI in SCI mode", 32'(smi_n), 1);
    wr(4'd1, 32'h80);
    chk("R4 SCI follows status", 32'(sci_line), 0);
    pulse_g(7);
    wr(4'd0, ctl(0, 1, 0, 0, 9)); tick();
    chk("R4 SMI mode no SCI", 32'(sci_line), 0);
    chk("R4 SMI mode SMI", 32'(smi_n), 0);
  endtask

  task automatic t_steer();
    int sels[8] = '{9, 10, 11, 12, 20, 21, 22, 23};
    cleanup();
    wr(4'd2, 32'h80);
    pulse_g(7);
    for (int ap = 0; ap < 2; ap++) begin
      foreach (sels[k]) begin
        logic [31:0] exp;
        int s;
        s = sels[k];
        exp = 0;
        if (s >= 9 && s <= 11) exp = 32'h1 << (s - 9);
        else if (s >= 20 && s <= 23 && ap == 1) exp = 32'h1 << (s - 17);
        wr(4'd0, ctl(1, 0, 0, ap[0], s));
        chk((s >= 20) ? "R9 APIC line" : "R8 line select", 32'(sci_line), exp);
      end
    end
  endtask

  task automatic t_gpi();
    logic [31:0] d;
    cleanup();
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd0, ctl(1, 0, 0, 0, 10));
    gpi_evt[20] = 1'b1; tick(); gpi_evt = '0;
    rd(4'd4, d); chk("R10 high GPI ignored", d, 0);
    chk("R10 high GPI no SCI", 32'(sci_line), 0);
    gpi_evt[4] = 1'b1; tick(); gpi_evt = '0;
    rd(4'd4, d); chk("R10 low GPI latched", d, 32'h10);
    chk("R10 low GPI SCI", 32'(sci_line), 32'h2);
  endtask

  task automatic t_pme();
    logic [31:0] d;
    cleanup();
    wr(4'd0, ctl(1, 0, 0, 0, 11));
    pme_msg = 1'b1; tick(); pme_msg = 1'b0;
    rd(4'd6, d); chk("R11 PME status", d, 32'h1);
    chk("R11 PME disabled", 32'(sci_line), 0);
    wr(4'd7, 32'h1);
    chk("R11 PME enabled SCI", 32'(sci_line), 32'h4);
  endtask

  task automatic t_pwrbtn();
    logic [31:0] d;
    cleanup();
    pwrbtn_ovr_evt = 1'b1; tick(); pwrbtn_ovr_evt = 1'b0;
    rd(4'd6, d); chk("R12 override status", d, 32'h2);
    chk("R12 no SCI before mode", 32'(sci_line), 0);
    wr(4'd0, ctl(1, 0, 0, 1, 21));
    chk("R12 SCI on mode set", 32'(sci_line), 32'h10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_gated();
    t_ungated();
    t_oneshot();
    t_gbl();
    t_sci();
    t_steer();
    t_gpi();
    t_pme();
    t_pwrbtn();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule